// File: doc/BRIEF.md
# Down-Counting Event Timer with One-Shot and Periodic Modes

This block is a 56-bit event timer on a plain 32-bit register bus. Software first stages the low 32 bits of a period in one register. It then writes a control word that carries the upper 24 bits together with a load request, a run enable and a periodic-mode select. The counter counts down by one on every cycle in which the `tick` enable is high. When the counter reaches zero it raises a pending flag, which reaches the `irq` output only while the interrupt mask is set.

In periodic mode the next tick after expiry reloads the whole 56-bit period and counting goes on. In one-shot mode the counter clears its own enable and holds at zero. The mask is controlled through two registers: writing a one to bit 0 of the first sets it, and writing a one to bit 0 of the second clears it. The pending flag is cleared by writing a one to bit 0 of its own register. Reads show the live counter, the run state and the interrupt state, so a driver can poll the timer or take interrupts.

Top module: `evt_timer`

## Requirements
- R1: After a synchronous active-low reset, the counter is 0, enable and periodic mode are off, the mask and the pending flag are 0, and `irq` is 0.
- R2: A write to offset 0x00 stages load bits [31:0]. The counter does not change until a control write commits the staged value.
- R3: A write to offset 0x04 sets the enable from bit 24 and periodic mode from bit 28. When bit 30 is 1, the value {wdata[23:0], staged low word} is committed, and the counter holds that value one cycle after the write.
- R4: The counter decreases by exactly one on each cycle in which `tick` is 1, the timer is enabled, and no commit or control write is in progress. A borrow runs across bit 32. In every other cycle the counter holds its value.
- R5: Expiry is a tick that takes the counter from 1 to 0. Expiry sets the pending flag whatever the mask state is.
- R6: In periodic mode, a tick that finds the counter at 0 reloads the last committed 56-bit value, and the timer stays enabled.
- R7: In one-shot mode, the enable clears at expiry and the counter then holds at 0 through later ticks.
- R8: A control write of all zeros stops the counter, and the counter keeps its current value.
- R9: Writing 1 in bit 0 of offset 0x2C sets the mask. Writing 1 in bit 0 of offset 0x30 clears it. Writes with bit 0 equal to 0 have no effect.
- R10: Writing 1 in bit 0 of offset 0x34 clears the pending flag. If an expiry happens in the same cycle, the set wins.
- R11: `irq` is 1 exactly when the pending flag and the mask are both 1.
- R12: Reads are combinational. 0x00 returns counter[31:0]. 0x04 returns counter[55:32] in bits [23:0], the enable in bit 24 and periodic mode in bit 28, with all other bits 0. 0x2C returns the mask in bit 0. 0x34 returns the pending flag in bit 0. Every other offset reads 0.
- R13: A control write with bit 30 equal to 0 changes only the enable and the mode. The counter continues from its current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable, one pulse per timer tick |
| bus_we | input | 1 | Write strobe for the current bus cycle |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request, pending AND mask |

## Verification
The assertions assume one bus access per cycle. A mask-set write and a mask-clear write therefore never land in the same cycle, and a control write never coincides with a staging write. They also assume that `tick` is an enable sampled on the clock, not a clock in its own right. The stimulus issues at most one register operation per cycle. It sends ticks on about half of the cycles, to random offsets including unmapped ones. It keeps most committed periods between 0 and 8, so that expiries, reloads, pending-clear races, and counts below the smallest useful period of 2 all occur often.

// File: rtl/evt_tmr_pkg.sv
// Package: register offsets and control-word bit positions shared by the
// timer modules. Offsets and control bits are fixed because software
// decodes them; widths come from the top-level parameters.
package evt_tmr_pkg;

    localparam int unsigned OFF_CNT_LO  = 32'h00;
    localparam int unsigned OFF_CTRL    = 32'h04;
    localparam int unsigned OFF_MSK_SET = 32'h2C;
    localparam int unsigned OFF_MSK_CLR = 32'h30;
    localparam int unsigned OFF_PND_CLR = 32'h34;

    localparam int unsigned CTL_EN_BIT  = 24;
    localparam int unsigned CTL_RPT_BIT = 28;
    localparam int unsigned CTL_LD_BIT  = 30;

    // One-hot write selects produced by the bus decoder.
    typedef struct packed {
        logic cnt_lo;
        logic ctrl;
        logic msk_set;
        logic msk_clr;
        logic pnd_clr;
    } wr_sel_t;

endpackage

// File: rtl/evt_tmr_bus.sv
// Module: evt_tmr_bus
// Decodes register writes into strobes, holds the staged low load word,
// and builds the combinational read data.
// Assumes one access per cycle and counter width in (DATA_W, DATA_W+24].
module evt_tmr_bus
    import evt_tmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 56
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              run_en,
    input  logic              run_rpt,
    input  logic              mask,
    input  logic              pend,
    output wr_sel_t           sel,
    output logic [DATA_W-1:0] lo_stage,
    output logic [CNT_W-DATA_W-1:0] ctl_hi,
    output logic              ctl_en,
    output logic              ctl_rpt,
    output logic              ctl_ld,
    output logic              msk_set_wr,
    output logic              msk_clr_wr,
    output logic              pnd_clr_wr,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int unsigned HI_W = CNT_W - DATA_W;

    logic is_lo, is_ctrl, is_mset, is_mclr, is_pclr;

    // Address match for each mapped register.
    always_comb begin
        is_lo   = (bus_addr == ADDR_W'(OFF_CNT_LO));
        is_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));
        is_mset = (bus_addr == ADDR_W'(OFF_MSK_SET));
        is_mclr = (bus_addr == ADDR_W'(OFF_MSK_CLR));
        is_pclr = (bus_addr == ADDR_W'(OFF_PND_CLR));
    end

    // Write strobes, qualified by the write enable.
    always_comb begin
        sel.cnt_lo  = bus_we && is_lo;
        sel.ctrl    = bus_we && is_ctrl;
        sel.msk_set = bus_we && is_mset;
        sel.msk_clr = bus_we && is_mclr;
        sel.pnd_clr = bus_we && is_pclr;
    end

    // Control fields and bit-0 qualified interrupt strobes.
    always_comb begin
        ctl_hi     = bus_wdata[HI_W-1:0];
        ctl_en     = bus_wdata[CTL_EN_BIT];
        ctl_rpt    = bus_wdata[CTL_RPT_BIT];
        ctl_ld     = bus_wdata[CTL_LD_BIT];
        msk_set_wr = sel.msk_set && bus_wdata[0];
        msk_clr_wr = sel.msk_clr && bus_wdata[0];
        pnd_clr_wr = sel.pnd_clr && bus_wdata[0];
    end

    // Staging register for the low load word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_stage <= '0;
        end else if (sel.cnt_lo) begin
            lo_stage <= bus_wdata;
        end
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (is_lo) begin
            bus_rdata = cnt[DATA_W-1:0];
        end else if (is_ctrl) begin
            bus_rdata[HI_W-1:0]   = cnt[CNT_W-1:DATA_W];
            bus_rdata[CTL_EN_BIT]  = run_en;
            bus_rdata[CTL_RPT_BIT] = run_rpt;
        end else if (is_mset) begin
            bus_rdata[0] = mask;
        end else if (is_pclr) begin
            bus_rdata[0] = pend;
        end
    end

    // R2: the staged word changes only on a write to its offset.
    p_stage_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sel.cnt_lo |=> $stable(lo_stage));

endmodule

// File: rtl/evt_tmr_core.sv
// Module: evt_tmr_core
// 56-bit down counter with a one-cycle commit stage, periodic reload and
// one-shot self-stop. Produces a single-cycle expire pulse when a tick
// takes the count from 1 to 0.
// Assumes tick is a clock-synchronous enable.
module evt_tmr_core #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 56
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic                    ctrl_wr,
    input  logic [CNT_W-DATA_W-1:0] ctl_hi,
    input  logic                    ctl_en,
    input  logic                    ctl_rpt,
    input  logic                    ctl_ld,
    input  logic [DATA_W-1:0]       lo_stage,
    output logic [CNT_W-1:0]        cnt,
    output logic                    run_en,
    output logic                    run_rpt,
    output logic                    expire
);

    logic [CNT_W-1:0] cnt_q, reload_q;
    logic             en_q, rpt_q, ld_pend_q;
    logic             step, at_one, at_zero;

    // Qualify a counting step and detect the boundary values.
    always_comb begin
        step    = tick && en_q && !ld_pend_q && !ctrl_wr;
        at_one  = (cnt_q == CNT_W'(1));
        at_zero = (cnt_q == '0);
        expire  = step && at_one;
    end

    // Control capture, commit, count, reload and one-shot stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            reload_q  <= '0;
            en_q      <= 1'b0;
            rpt_q     <= 1'b0;
            ld_pend_q <= 1'b0;
        end else if (ctrl_wr) begin
            en_q  <= ctl_en;
            rpt_q <= ctl_rpt;
            if (ctl_ld) begin
                ld_pend_q <= 1'b1;
                reload_q  <= {ctl_hi, lo_stage};
            end
        end else if (ld_pend_q) begin
            cnt_q     <= reload_q;
            ld_pend_q <= 1'b0;
        end else if (step) begin
            if (at_zero) begin
                if (rpt_q) cnt_q <= reload_q;
                else       en_q  <= 1'b0;
            end else begin
                cnt_q <= cnt_q - CNT_W'(1);
                if (at_one && !rpt_q) en_q <= 1'b0;
            end
        end
    end

    assign cnt     = cnt_q;
    assign run_en  = en_q;
    assign run_rpt = rpt_q;

    // R3: a pending commit lands the captured value in the counter.
    p_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_pend_q && !ctrl_wr) |=> (cnt_q == $past(reload_q)));

    // R3: the enable follows the control write.
    p_en_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (en_q == $past(ctl_en)));

    // R4: without tick, commit or control write the counter holds.
    p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ld_pend_q && !ctrl_wr) |=> $stable(cnt_q));

    // R6: periodic mode reloads from zero on the next tick.
    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && at_zero && rpt_q) |=> (cnt_q == $past(reload_q)) && en_q);

    // R7: one-shot expiry drops the enable and leaves zero.
    p_oneshot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !rpt_q) |=> (!en_q && cnt_q == '0));

endmodule

// File: rtl/evt_tmr_irq.sv
// Module: evt_tmr_irq
// Interrupt mask with separate set and clear strobes, and a pending flag
// set by expiry and cleared by software; a same-cycle expiry beats clear.
// Assumes mask set and clear strobes never coincide.
module evt_tmr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic msk_set_wr,
    input  logic msk_clr_wr,
    input  logic pnd_clr_wr,
    output logic mask,
    output logic pend,
    output logic irq
);

    // Mask register driven by the set and clear strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)          mask <= 1'b0;
        else if (msk_set_wr) mask <= 1'b1;
        else if (msk_clr_wr) mask <= 1'b0;
    end

    // Pending flag: expiry sets, write-one clears.
    always_ff @(posedge clk) begin
        if (!rst_n)          pend <= 1'b0;
        else if (expire)     pend <= 1'b1;
        else if (pnd_clr_wr) pend <= 1'b0;
    end

    assign irq = pend & mask;

    // R5: every expiry leaves the flag pending.
    p_pend_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> pend);

    // R10: a clear without a racing expiry drops the flag.
    p_pend_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pnd_clr_wr && !expire) |=> !pend);

    // R9: the set strobe raises the mask.
    p_mask_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
        msk_set_wr |=> mask);

    // R9: the clear strobe drops the mask.
    p_mask_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (msk_clr_wr && !msk_set_wr) |=> !mask);

endmodule

// File: rtl/evt_timer.sv
// Module: evt_timer (top)
// Memory-mapped 56-bit one-shot/periodic event timer. Connects the bus
// decoder, the down counter and the interrupt logic.
// Assumes the counter is wider than the data bus by at most 24 bits.
module evt_timer
    import evt_tmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 56
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    localparam int unsigned HI_W = CNT_W - DATA_W;

    wr_sel_t            sel;
    logic [DATA_W-1:0]  lo_stage;
    logic [HI_W-1:0]    ctl_hi;
    logic               ctl_en, ctl_rpt, ctl_ld;
    logic               msk_set_wr, msk_clr_wr, pnd_clr_wr;
    logic [CNT_W-1:0]   cnt;
    logic               run_en, run_rpt, expire, mask, pend;

    evt_tmr_bus #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .cnt        (cnt),
        .run_en     (run_en),
        .run_rpt    (run_rpt),
        .mask       (mask),
        .pend       (pend),
        .sel        (sel),
        .lo_stage   (lo_stage),
        .ctl_hi     (ctl_hi),
        .ctl_en     (ctl_en),
        .ctl_rpt    (ctl_rpt),
        .ctl_ld     (ctl_ld),
        .msk_set_wr (msk_set_wr),
        .msk_clr_wr (msk_clr_wr),
        .pnd_clr_wr (pnd_clr_wr),
        .bus_rdata  (bus_rdata)
    );

    evt_tmr_core #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .ctrl_wr  (sel.ctrl),
        .ctl_hi   (ctl_hi),
        .ctl_en   (ctl_en),
        .ctl_rpt  (ctl_rpt),
        .ctl_ld   (ctl_ld),
        .lo_stage (lo_stage),
        .cnt      (cnt),
        .run_en   (run_en),
        .run_rpt  (run_rpt),
        .expire   (expire)
    );

    evt_tmr_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire     (expire),
        .msk_set_wr (msk_set_wr),
        .msk_clr_wr (msk_clr_wr),
        .pnd_clr_wr (pnd_clr_wr),
        .mask       (mask),
        .pend       (pend),
        .irq        (irq)
    );

    // R11: the request line never rises without the mask.
    p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (u_irq.mask && u_irq.pend));

endmodule

// File: tb/test_evt_timer.sv
// Bench for evt_timer: directed corner cases followed by seeded random
// traffic, checked against a cycle model written from the requirements.
module test_evt_timer;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;

    // Reference state.
    logic [55:0] m_cnt = '0, m_reload = '0;
    logic [31:0] m_lo = '0;
    logic        m_en = 0, m_rpt = 0, m_lpend = 0, m_mask = 0, m_pend = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_timer i_evt_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model next state from the requirements (R3..R10, R13).
    task automatic model_step(input logic we, input logic [7:0] a,
                              input logic [31:0] d, input logic tk);
        logic cw, st, ex;
        cw = we && (a == 8'h04);
        st = tk && m_en && !m_lpend && !cw;
        ex = st && (m_cnt == 56'd1);
        if (cw) begin
            m_en  = d[24];
            m_rpt = d[28];
            if (d[30]) begin
                m_lpend  = 1'b1;
                m_reload = {d[23:0], m_lo};
            end
        end else if (m_lpend) begin
            m_cnt   = m_reload;
            m_lpend = 1'b0;
        end else if (st) begin
            if (m_cnt == '0) begin
                if (m_rpt) m_cnt = m_reload;
                else       m_en  = 1'b0;
            end else begin
                if (m_cnt == 56'd1 && !m_rpt) m_en = 1'b0;
                m_cnt = m_cnt - 56'd1;
            end
        end
        if (ex) m_pend = 1'b1;
        else if (we && a == 8'h34 && d[0]) m_pend = 1'b0;
        if (we && a == 8'h2C && d[0]) m_mask = 1'b1;
        if (we && a == 8'h30 && d[0]) m_mask = 1'b0;
        if (we && a == 8'h00) m_lo = d;
    endtask

    // Expected read data (R12).
    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        logic [31:0] r;
        r = '0;
        case (a)
            8'h00: r = m_cnt[31:0];
            8'h04: begin r[23:0] = m_cnt[55:32]; r[24] = m_en; r[28] = m_rpt; end
            8'h2C: r[0] = m_mask;
            8'h34: r[0] = m_pend;
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string rd_tag(input logic [7:0] a);
        case (a)
            8'h00:   return "R4";
            8'h2C:   return "R9";
            8'h34:   return "R10";
            default: return "R12";
        endcase
    endfunction

    // One bus cycle: drive at negedge, model at posedge, compare after it.
    task automatic cyc(input logic we, input logic [7:0] a,
                       input logic [31:0] d, input logic tk);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d; tick = tk;
        @(posedge clk);
        model_step(we, a, d, tk);
        #1;
        chk({31'd0, irq}, {31'd0, m_pend && m_mask}, "R11");
        chk(bus_rdata, exp_rd(a), rd_tag(a));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state.
        cyc(0, 8'h00, 0, 0); chk(bus_rdata, 32'h0, "R1");
        cyc(0, 8'h04, 0, 0); chk(bus_rdata, 32'h0, "R1");
        cyc(0, 8'h34, 0, 1); chk(bus_rdata, 32'h0, "R1"); chk({31'd0, irq}, 0, "R1");

        // R2: staging leaves the counter alone.
        cyc(1, 8'h00, 32'd3, 0);
        cyc(0, 8'h00, 0, 1); chk(bus_rdata, 32'h0, "R2");

        // R3: commit one-shot period 3.
        cyc(1, 8'h04, 32'h4100_0000, 1); chk(bus_rdata, 32'h0100_0000, "R3");
        cyc(0, 8'h00, 0, 1); chk(bus_rdata, 32'd3, "R3");

        // R4/R5/R7: count down and expire with mask off.
        cyc(0, 8'h00, 0, 1); chk(bus_rdata, 32'd2, "R4");
        cyc(0, 8'h00, 0, 0); chk(bus_rdata, 32'd2, "R4");
        cyc(0, 8'h00, 0, 1); chk(bus_rdata, 32'd1, "R4");
        cyc(0, 8'h34, 0, 1); chk(bus_rdata, 32'd1, "R5");
        chk({31'd0, irq}, 0, "R11");
        cyc(0, 8'h04, 0, 1); chk(bus_rdata, 32'h0, "R7");
        cyc(0, 8'h00, 0, 1); chk(bus_rdata, 32'h0, "R7");

        // R9/R11: mask writes.
        cyc(1, 8'h2C, 32'h0, 0); chk(bus_rdata, 32'h0, "R9");
        cyc(1, 8'h2C, 32'h1, 0); chk(bus_rdata, 32'h1, "R9");
        chk({31'd0, irq}, 1, "R11");
        cyc(1, 8'h30, 32'h0, 0); chk({31'd0, irq}, 1, "R9");
        // R10: clear pending.
        cyc(1, 8'h34, 32'h1, 0); chk(bus_rdata, 32'h0, "R10");
        chk({31'd0, irq}, 0, "R10");

        // R6: periodic period 2.
        cyc(1, 8'h00, 32'd2, 0);
        cyc(1, 8'h04, 32'h5100_0000, 0);
        cyc(0, 8'h00, 0, 0); chk(bus_rdata, 32'd2, "R6");
        cyc(0, 8'h00, 0, 1);
        cyc(0, 8'h00, 0, 1); chk(bus_rdata, 32'd0, "R6");
        chk({31'd0, irq}, 1, "R11");
        cyc(0, 8'h00, 0, 1); chk(bus_rdata, 32'd2, "R6");
        cyc(0, 8'h04, 0, 0); chk(bus_rdata, 32'h1100_0000, "R6");

        // R8: stop holds the value.
        cyc(1, 8'h04, 32'h0, 0);
        cyc(0, 8'h00, 0, 1); chk(bus_rdata, 32'd2, "R8");
        // R13: enable without load resumes from current value.
        cyc(1, 8'h04, 32'h0100_0000, 1);
        cyc(0, 8'h00, 0, 0); chk(bus_rdata, 32'd2, "R13");
        cyc(0, 8'h00, 0, 1); chk(bus_rdata, 32'd1, "R13");

        // R4: borrow across bit 32.
        cyc(1, 8'h34, 32'h1, 0);
        cyc(1, 8'h00, 32'h0, 0);
        cyc(1, 8'h04, 32'h4100_0001, 0);
        cyc(0, 8'h04, 0, 0); chk(bus_rdata, 32'h0100_0001, "R3");
        cyc(0, 8'h04, 0, 1); chk(bus_rdata, 32'h0100_0000, "R4");
        cyc(0, 8'h00, 0, 0); chk(bus_rdata, 32'hFFFF_FFFF, "R4");

        // R12: unmapped offset.
        cyc(0, 8'h10, 0, 0); chk(bus_rdata, 32'h0, "R12");
        cyc(1, 8'h04, 32'h0, 0);

        // Seeded random traffic against the model.
        for (int i = 0; i < 4000; i++) begin
            logic        we, tk;
            logic [7:0]  a;
            logic [31:0] d;
            int          sel;
            tk  = ($urandom % 2) == 1;
            we  = ($urandom % 4) == 0;
            sel = $urandom % 6;
            case (sel)
                0: a = 8'h00;
                1: a = 8'h04;
                2: a = 8'h2C;
                3: a = 8'h30;
                4: a = 8'h34;
                default: a = 8'h10;
            endcase
            d = $urandom;
            if (a == 8'h00) d = $urandom % 9;
            if (a == 8'h04) begin
                d[23:0] = (($urandom % 16) == 0) ? 24'd1 : 24'd0;
                d[27:25] = '0;
                d[31:29] = {1'b0, d[30], 1'b0};
                d[30] = ($urandom % 4) != 0;
            end
            cyc(we, a, d, tk);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule